// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Load Cache

This block is a 16KB, 4-way set-associative first-level data cache that serves loads only. A load supplies its virtual address when it is issued. The set is picked from the untranslated virtual bits, so the tag and data arrays are read while translation is still running. The physical page number arrives from the translation stage one cycle later and is compared against the four stored tags. Each line holds 32 bytes (eight 32-bit words). Tags and line data live in separate arrays.

A hit gives the addressed word three cycles after the load is accepted, and loads can be issued back to back. A miss stops new loads and picks a victim way. The first invalid way is preferred; when the set is full, a per-set round-robin pointer chooses. The block then fetches the whole line over a simple valid/ready memory port, installs it, and returns the requested word as a miss response.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid. `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_valid_o` is 0, and the first load to any address misses.
- R2: A load accepted in cycle T (`req_valid_i` and `req_ready_o` both 1) that hits shows `rsp_valid_o`=1, `rsp_hit_o`=1 and its word in cycle T+3.
- R3: The set is `req_vaddr_i[11:5]`, the word is `req_vaddr_i[4:2]`, and the tag compared is `xlat_ptag_i` as driven in cycle T+1. The same virtual address with a different physical tag misses.
- R4: On a miss, `mem_req_addr_o` = {physical tag, set, 5'b0}. It is held stable with `mem_req_valid_o`=1 until `mem_req_ready_i` is 1.
- R5: A refill takes eight beats on `mem_rvalid_i`, and beat k is the word at line address + 4k. One cycle after the last beat, a response arrives with `rsp_hit_o`=0, the filled way on `rsp_way_o`, and the requested word.
- R6: `req_ready_o` is 0 from cycle T+1 of a missing load until its refill completes. No hit response overlaps a refill response.
- R7: A miss fills the lowest-numbered invalid way of its set if there is one.
- R8: In a full set, the victim is taken from a per-set pointer. The pointer starts at way 0 and advances by one, wrapping, on each eviction in that set.
- R9: Four different lines that map to one set stay resident together and all hit, each in its own way.
- R10: Hitting loads may be accepted on consecutive cycles, and each returns in order with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request |
| req_ready_o | output | 1 | Load accepted when high with req_valid_i |
| req_vaddr_i | input | 32 | Virtual byte address of the load |
| xlat_ptag_i | input | 20 | Physical page number, driven the cycle after acceptance |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | 1 for a hit, 0 for a refill response |
| rsp_way_o | output | 2 | Way that hit or was filled |
| rsp_data_o | output | 32 | Loaded word |
| mem_req_valid_o | output | 1 | Line fetch request |
| mem_req_ready_i | input | 1 | Line fetch accepted |
| mem_req_addr_o | output | 32 | Line-aligned physical address |
| mem_rvalid_i | input | 1 | Refill beat valid |
| mem_rdata_i | input | 32 | Refill beat data |

## Verification
The hardest state to reach is a full set whose round-robin pointer has already wrapped, followed by a reload of a line that was just evicted. Only the exact order of misses to one set leads there. The stimulus drives six physical tags through one set with the same virtual address. Then a long run of loads picks from six tags per set over a few sets, so evictions repeat. A reference model in the bench tracks validity, tags and pointers per set and predicts the way of every response. The same virtual address is also loaded under changing physical tags to show that the compare uses only the translated page.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE,
    FILL_REQ,
    FILL_DATA
  } fill_state_e;
endpackage

// File: rtl/vipt_sram.sv
module vipt_sram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 20,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vipt_victim.sv
module vipt_victim #(
  parameter int unsigned SETS = 128,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] look_set_i,
  output logic [WAYS-1:0]  look_vld_o,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             done_i,
  input  logic [IDX_W-1:0] done_set_i,
  input  logic [WAY_W-1:0] done_way_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];
  logic [WAYS-1:0]  alloc_vld;
  logic             set_full;

  assign look_vld_o = valid_q[look_set_i];
  assign alloc_vld  = valid_q[alloc_set_i];
  assign set_full   = &alloc_vld;

  // lowest invalid way wins, else the round-robin pointer
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = rr_q[alloc_set_i];
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!found && !alloc_vld[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SETS); s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      if (alloc_i) begin
        valid_q[alloc_set_i][victim_o] <= 1'b0;
        if (set_full) rr_q[alloc_set_i] <= rr_q[alloc_set_i] + 1'b1;
      end
      if (done_i) valid_q[done_set_i][done_way_i] <= 1'b1;
    end
  end

  AST_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !set_full) |-> !alloc_vld[victim_o]); // R7
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && look_set_i == done_set_i) |=> look_vld_o[$past(done_way_i)] || (look_set_i != $past(look_set_i))); // R5
endmodule

// File: rtl/vipt_refill.sv
module vipt_refill
  import vipt_dcache_pkg::*;
#(
  parameter int unsigned PA_W   = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned WOFF_W = 3,
  parameter int unsigned WAY_W  = 2,
  localparam int unsigned TAG_W = PA_W - IDX_W - OFF_W,
  localparam int unsigned WORDS = 1 << WOFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WOFF_W-1:0] woff_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              wr_en_o,
  output logic [WOFF_W-1:0] wr_word_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [WORD_W-1:0] crit_o
);
  localparam logic [WOFF_W-1:0] LAST = WOFF_W'(WORDS - 1);

  fill_state_e       state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WOFF_W-1:0] woff_q;
  logic [WAY_W-1:0]  way_q;
  logic [WOFF_W-1:0] beat_q;
  logic [WORD_W-1:0] crit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      woff_q  <= '0;
      way_q   <= '0;
      beat_q  <= '0;
      crit_q  <= '0;
    end else begin
      unique case (state_q)
        FILL_IDLE: if (start_i) begin
          state_q <= FILL_REQ;
          tag_q   <= tag_i;
          idx_q   <= idx_i;
          woff_q  <= woff_i;
          way_q   <= way_i;
        end
        FILL_REQ: if (mem_req_ready_i) begin
          state_q <= FILL_DATA;
          beat_q  <= '0;
        end
        FILL_DATA: if (mem_rvalid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == woff_q) crit_q <= mem_rdata_i;
          if (beat_q == LAST) state_q <= FILL_IDLE;
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != FILL_IDLE);
  assign mem_req_valid_o = (state_q == FILL_REQ);
  assign mem_req_addr_o  = {tag_q, idx_q, {OFF_W{1'b0}}};
  assign wr_en_o         = (state_q == FILL_DATA) && mem_rvalid_i;
  assign wr_word_o       = beat_q;
  assign wr_data_o       = mem_rdata_i;
  assign done_o          = wr_en_o && (beat_q == LAST);
  assign tag_o           = tag_q;
  assign idx_o           = idx_q;
  assign way_o           = way_q;
  assign crit_o          = (beat_q == woff_q) ? mem_rdata_i : crit_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R4
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R6
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_dcache_pkg::*;
#(
  parameter int unsigned PA_W       = 32,
  parameter int unsigned VA_W       = 32,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SETS       = 128,
  parameter int unsigned WAYS       = 4,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned BOFF_W = $clog2(WORD_W / 8),
  localparam int unsigned WOFF_W = OFF_W - BOFF_W,
  localparam int unsigned WORDS  = 1 << WOFF_W,
  localparam int unsigned TAG_W  = PA_W - IDX_W - OFF_W,
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [TAG_W-1:0]  xlat_ptag_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic              accept;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_woff;
  logic              unused_va;

  logic              s1_valid_q;
  logic [IDX_W-1:0]  s1_idx_q;
  logic [WOFF_W-1:0] s1_woff_q;
  logic [WAYS-1:0]   s1_vld;
  logic [WAYS-1:0]   hit_vec;
  logic              s1_hit;
  logic [WAY_W-1:0]  hit_way;
  logic              miss_start;
  logic [TAG_W-1:0]  tag_rd  [WAYS];
  logic [WORD_W-1:0] data_rd [WAYS];

  logic              s2_valid_q;
  logic [WAY_W-1:0]  s2_way_q;
  logic [WORD_W-1:0] s2_data_q;

  logic              rsp_valid_q;
  logic              rsp_hit_q;
  logic [WAY_W-1:0]  rsp_way_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [WAY_W-1:0]  victim;
  logic              fill_busy;
  logic              fill_we;
  logic [WOFF_W-1:0] fill_word;
  logic [WORD_W-1:0] fill_wdata;
  logic              fill_done;
  logic [TAG_W-1:0]  fill_tag;
  logic [IDX_W-1:0]  fill_idx;
  logic [WAY_W-1:0]  fill_way;
  logic [WORD_W-1:0] fill_crit;

  // set and word come from the untranslated low bits
  assign req_idx   = req_vaddr_i[OFF_W +: IDX_W];
  assign req_woff  = req_vaddr_i[BOFF_W +: WOFF_W];
  assign unused_va = ^{req_vaddr_i[VA_W-1:OFF_W+IDX_W], req_vaddr_i[BOFF_W-1:0]};

  assign miss_start  = s1_valid_q && !s1_hit;
  assign req_ready_o = !fill_busy && !miss_start;
  assign accept      = req_valid_i && req_ready_o;

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    vipt_sram #(.DEPTH(SETS), .WIDTH(TAG_W)) i_tag_ram (
      .clk_i   (clk_i),
      .we_i    (fill_done && (fill_way == WAY_W'(w))),
      .waddr_i (fill_idx),
      .wdata_i (fill_tag),
      .re_i    (accept),
      .raddr_i (req_idx),
      .rdata_o (tag_rd[w])
    );
    vipt_sram #(.DEPTH(SETS * WORDS), .WIDTH(WORD_W)) i_data_ram (
      .clk_i   (clk_i),
      .we_i    (fill_we && (fill_way == WAY_W'(w))),
      .waddr_i ({fill_idx, fill_word}),
      .wdata_i (fill_wdata),
      .re_i    (accept),
      .raddr_i ({req_idx, req_woff}),
      .rdata_o (data_rd[w])
    );
    assign hit_vec[w] = s1_valid_q && s1_vld[w] && (tag_rd[w] == xlat_ptag_i);
  end

  assign s1_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  vipt_victim #(.SETS(SETS), .WAYS(WAYS)) i_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_set_i  (s1_idx_q),
    .look_vld_o  (s1_vld),
    .alloc_i     (miss_start),
    .alloc_set_i (s1_idx_q),
    .victim_o    (victim),
    .done_i      (fill_done),
    .done_set_i  (fill_idx),
    .done_way_i  (fill_way)
  );

  vipt_refill #(
    .PA_W(PA_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .WOFF_W(WOFF_W), .WAY_W(WAY_W)
  ) i_refill (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (miss_start),
    .tag_i           (xlat_ptag_i),
    .idx_i           (s1_idx_q),
    .woff_i          (s1_woff_q),
    .way_i           (victim),
    .busy_o          (fill_busy),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rvalid_i    (mem_rvalid_i),
    .mem_rdata_i     (mem_rdata_i),
    .wr_en_o         (fill_we),
    .wr_word_o       (fill_word),
    .wr_data_o       (fill_wdata),
    .done_o          (fill_done),
    .tag_o           (fill_tag),
    .idx_o           (fill_idx),
    .way_o           (fill_way),
    .crit_o          (fill_crit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_idx_q    <= '0;
      s1_woff_q   <= '0;
      s2_valid_q  <= 1'b0;
      s2_way_q    <= '0;
      s2_data_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_way_q   <= '0;
      rsp_data_q  <= '0;
    end else begin
      s1_valid_q <= accept;
      if (accept) begin
        s1_idx_q  <= req_idx;
        s1_woff_q <= req_woff;
      end
      s2_valid_q <= s1_valid_q && s1_hit;
      if (s1_valid_q && s1_hit) begin
        s2_way_q  <= hit_way;
        s2_data_q <= data_rd[hit_way];
      end
      rsp_valid_q <= s2_valid_q || fill_done;
      if (s2_valid_q) begin
        rsp_hit_q  <= 1'b1;
        rsp_way_q  <= s2_way_q;
        rsp_data_q <= s2_data_q;
      end else if (fill_done) begin
        rsp_hit_q  <= 1'b0;
        rsp_way_q  <= fill_way;
        rsp_data_q <= fill_crit;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_way_o   = rsp_way_q;
  assign rsp_data_o  = rsp_data_q;

  AST_ONE_WAY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |-> $onehot0(hit_vec)); // R9
  AST_HIT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> $past(req_valid_i && req_ready_o, 3)); // R2
  AST_STALL_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_busy |-> !s1_valid_q); // R6
  AST_RSP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s2_valid_q && fill_done)); // R6
endmodule

// File: tb/test_vipt_dcache.sv
`timescale 1ns/1ps
module test_vipt_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [19:0] xlat_ptag = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  vipt_dcache i_vipt_dcache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .xlat_ptag_i(xlat_ptag),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic        hit;
    logic [1:0]  way;
    logic [31:0] data;
    logic [31:0] cyc;
  } exp_t;

  exp_t        exp_q[$];
  string       lbl_q[$];
  logic [31:0] fill_q[$];
  int          n_chk = 0, n_fail = 0;
  logic [31:0] cyc = '0;

  bit          m_vld [128][4];
  logic [19:0] m_tag [128][4];
  logic [1:0]  m_rr  [128];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] va, input logic [19:0] pt);
    exp_t e;
    int   s;
    bit   found;
    s = int'(va[11:5]);
    found = 1'b0;
    e.hit = 1'b0; e.way = '0;
    for (int w = 0; w < 4; w++)
      if (!found && m_vld[s][w] && m_tag[s][w] == pt) begin
        found = 1'b1; e.hit = 1'b1; e.way = 2'(w);
      end
    if (!found) begin
      bit inv;
      inv = 1'b0;
      for (int w = 0; w < 4; w++)
        if (!inv && !m_vld[s][w]) begin inv = 1'b1; e.way = 2'(w); end
      if (!inv) begin e.way = m_rr[s]; m_rr[s] = m_rr[s] + 2'd1; end
      m_vld[s][e.way] = 1'b1;
      m_tag[s][e.way] = pt;
    end
    e.data = mem_word({pt, va[11:2], 2'b00});
    return e;
  endfunction

  // called at a falling edge
  task automatic issue(input logic [31:0] va, input logic [19:0] pt, input string req);
    exp_t e;
    req_valid = 1'b1;
    req_vaddr = va;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    e = model(va, pt);
    e.cyc = cyc + 3;
    exp_q.push_back(e);
    lbl_q.push_back(req);
    if (!e.hit) fill_q.push_back({pt, va[11:5], 5'b0});
    @(negedge clk);
    req_valid = 1'b0;
    xlat_ptag = pt;
    if (!e.hit) begin
      #1;
      check(req_ready == 1'b0, "R6", "ready during miss", 32'(req_ready), 0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t  e;
        string l;
        e = exp_q.pop_front();
        l = lbl_q.pop_front();
        check(rsp_hit == e.hit, l, "hit flag", 32'(rsp_hit), 32'(e.hit));
        check(rsp_way == e.way, l, "way", 32'(rsp_way), 32'(e.way));
        check(rsp_data == e.data, l, "data", rsp_data, e.data);
        if (e.hit) check(cyc == e.cyc, "R2", "hit latency", cyc, e.cyc);
      end
    end
  end

  // next-level memory
  initial begin
    int nf;
    nf = 0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        if (fill_q.size() == 0) check(1'b0, "R4", "unexpected fetch", a, 0);
        else begin
          logic [31:0] ea;
          ea = fill_q.pop_front();
          check(a == ea, "R4", "fetch address", a, ea);
        end
        repeat (nf % 3) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == a, "R4", "request held", mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int k = 0; k < 8; k++) begin
          if (k == 3 && nf[0]) begin
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(a + 32'(4 * k));
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        nf++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = '0;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R1", "no fetch after reset", 32'(mem_req_valid), 0);

    issue(32'hABCD_0068, 20'h12345, "R1");        // set 3, word 2: cold miss
    issue(32'hABCD_0068, 20'h12345, "R2");        // hit
    issue(32'h0000_0068, 20'h12345, "R3");        // other virtual page bits, same line
    issue(32'hABCD_0068, 20'h22222, "R3");        // same VA, new tag -> way 1
    issue(32'h0000_0060, 20'h33333, "R7");        // way 2
    issue(32'h0000_007C, 20'h44444, "R7");        // way 3
    issue(32'h0000_0064, 20'h12345, "R9");
    issue(32'h0000_0064, 20'h22222, "R9");
    issue(32'h0000_0064, 20'h33333, "R10");
    issue(32'h0000_0064, 20'h44444, "R10");
    issue(32'h0000_0070, 20'h55555, "R8");        // evict way 0
    issue(32'h0000_0070, 20'h66666, "R8");        // evict way 1
    issue(32'h0000_0070, 20'h12345, "R8");        // reload, evict way 2
    issue(32'h0000_0070, 20'h55555, "R10");
    for (int k = 0; k < 8; k++)
      issue(32'h0000_0460 + 32'(4 * k), 20'h0BEEF, "R5");  // set 35 walk
    for (int k = 7; k >= 0; k--)
      issue(32'h0000_0460 + 32'(4 * k), 20'h0BEEF, "R10");
    issue(32'h0000_0FE0, 20'h12345, "R3");        // set 127, same tag as set 3
    issue(32'h0000_0068, 20'h33333, "R3");
    for (int n = 0; n < 300; n++) begin
      logic [6:0]  st;
      logic [31:0] va;
      st = 7'(8 + ($urandom % 3) * 17);
      va = {$urandom} & 32'hFFFF_F000;
      va = va | {20'h0, st, 3'($urandom), 2'b00};
      issue(va, 20'(20'h70000 + ($urandom % 6)), "R8");
    end
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all responses seen", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule